// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the low-power states of a DDR memory device as they are steered by the clock-enable input. On every rising clock edge it samples clock-enable, a decoded command code and a flag that says whether every bank is idle. It keeps the clock-enable value from the previous edge, so entry and exit decisions depend on clock-enable in two consecutive edges together with the command that arrived with the second one.

The controller starts in a power-up wait. It leaves that wait only after a long unbroken run of cycles with clock-enable high and the chip deselected. It then enters the ready state, where commands are accepted. A falling clock-enable with a refresh command enters self-refresh. A falling clock-enable with a no-op or deselect enters power-down. Both entries need all banks idle. A rising clock-enable with a no-op or deselect starts a timed wake-up. A single down-counter times the wake-up and blocks command acceptance until it runs out. Bad combinations raise a one-cycle illegal flag and leave the state unchanged. A separate output asks the data and strobe drivers to go to high impedance.

All outputs are registered state or simple decodes of it, so every response to a sampled input appears right after the edge that sampled it.

Top module: `cke_power_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (power-up wait). It moves to 1 (ready) on the edge that samples the INIT_CYCLES-th (default 200) consecutive cycle with `cke_i`=1 and `cmd_i`=0 (deselect). Any other sample during the wait restarts the count. `cmd_accept_o` is 1 exactly while `state_o` is 1.
- R2: In ready, an edge that samples `cke_i`=0 after a previous sample of 1, with `cmd_i`=2 (auto-refresh) and `banks_idle_i`=1, moves `state_o` to 3 (self-refresh).
- R3: In ready, a falling clock-enable with `cmd_i`=1 (no-op) or 0 (deselect) and `banks_idle_i`=1 moves `state_o` to 2 (power-down). The same pattern with `banks_idle_i`=0 pulses `illegal_o` and the state stays ready.
- R4: In self-refresh, an edge that samples `cke_i`=1 with no-op or deselect moves `state_o` to 4 (waking). It returns to ready on the SREF_EXIT_CYCLES-th (default 200) following edge.
- R5: In power-down, an edge that samples `cke_i`=1 with no-op or deselect moves `state_o` to 4. It returns to ready on the PDOWN_EXIT_CYCLES-th (default 2) following edge. `cmd_accept_o` stays 0 throughout the wake.
- R6: While `cke_i` is sampled 0 in power-down or self-refresh, the state is kept, the command and bank-idle inputs are ignored, and `illegal_o` stays 0.
- R7: `output_hiz_o` is 1 whenever the last sampled `cke_i` is 0 or `state_o` is not ready. It is 0 in ready with clock-enable high.
- R8: In power-down or self-refresh, sampling `cke_i`=1 with a command code other than 0 or 1 sets `illegal_o` for one cycle and the state is kept.
- R9: In ready, a falling clock-enable with auto-refresh while `banks_idle_i`=0 sets `illegal_o` for one cycle and keeps ready. So does a falling clock-enable with any command code of 3 to 7 (activate, read, write, precharge, mode set).
- R10: During the wake, `cke_i`, `cmd_i` and `banks_idle_i` do not change the countdown or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock-enable level for this edge |
| cmd_i | input | 3 | Decoded command: 0 deselect, 1 no-op, 2 auto-refresh, 3 activate, 4 read, 5 write, 6 precharge, 7 mode set |
| banks_idle_i | input | 1 | 1 when no bank is open |
| state_o | output | 3 | 0 power-up wait, 1 ready, 2 power-down, 3 self-refresh, 4 waking |
| cmd_accept_o | output | 1 | Commands may be issued |
| illegal_o | output | 1 | One-cycle pulse after an illegal clock-enable transition |
| output_hiz_o | output | 1 | Request to hold data and strobe drivers in high impedance |

## Verification
A wrong internal state shows directly on `state_o`, and on `cmd_accept_o` and `output_hiz_o`, right after the edge that sampled the bad input. A miscounted timer shows only at the end of a window. A timer that is one short or one long moves the return to ready by one edge, after 2 or 200 cycles, or at the end of the 200-cycle start-up run. So the wake and power-up windows are checked on both sides of their final edge. A lost previous clock-enable value shows as a missed or spurious entry into a low-power state on the first falling edge.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_READY = 3'd1,
    ST_PDOWN = 3'd2,
    ST_SREF  = 3'd3,
    ST_WAKE  = 3'd4
  } pwr_state_e;

  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_AREF  = 3'd2,
    CMD_ACT   = 3'd3,
    CMD_READ  = 3'd4,
    CMD_WRITE = 3'd5,
    CMD_PRE   = 3'd6,
    CMD_MRS   = 3'd7
  } pwr_cmd_e;

  function automatic logic is_quiet(input pwr_cmd_e c);
    return (c == CMD_DESEL) || (c == CMD_NOP);
  endfunction

  function automatic logic is_low_power(input pwr_state_e s);
    return (s == ST_PDOWN) || (s == ST_SREF);
  endfunction

endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_i,
  output logic cke_q_o,
  output logic fall_o
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke_i;
  end

  assign cke_q_o = cke_q;
  assign fall_o  = cke_q & ~cke_i;
endmodule

// File: rtl/pwr_down_timer.sv
module pwr_down_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 199
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= CNT_W'(RST_VAL);
    else if (load_i)                cnt <= load_val_i;
    else if (dec_i && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import cke_pwr_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int INIT_CYCLES  = 200,
  parameter int SREF_CYCLES  = 200,
  parameter int PDOWN_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  pwr_cmd_e         cmd_i,
  input  logic             banks_idle_i,
  input  logic             fall_i,
  input  logic             zero_i,
  output pwr_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             dec_o,
  output logic             illegal_o
);
  localparam logic [CNT_W-1:0] INIT_LD  = CNT_W'(INIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SREF_LD  = CNT_W'(SREF_CYCLES - 1);
  localparam logic [CNT_W-1:0] PDOWN_LD = CNT_W'(PDOWN_CYCLES - 1);

  pwr_state_e state_q, state_d;
  logic       bad_d, bad_q;

  always_comb begin
    state_d    = state_q;
    bad_d      = 1'b0;
    load_o     = 1'b0;
    load_val_o = INIT_LD;
    dec_o      = 1'b0;
    unique case (state_q)
      ST_PWRUP: begin
        if (!(cke_i && cmd_i == CMD_DESEL)) begin
          load_o     = 1'b1;
          load_val_o = INIT_LD;
        end else if (zero_i) begin
          state_d = ST_READY;
        end else begin
          dec_o = 1'b1;
        end
      end
      ST_READY: begin
        if (fall_i) begin
          if (cmd_i == CMD_AREF && banks_idle_i)       state_d = ST_SREF;
          else if (is_quiet(cmd_i) && banks_idle_i)    state_d = ST_PDOWN;
          else                                         bad_d   = 1'b1;
        end
      end
      ST_PDOWN, ST_SREF: begin
        if (cke_i) begin
          if (is_quiet(cmd_i)) begin
            state_d    = ST_WAKE;
            load_o     = 1'b1;
            load_val_o = (state_q == ST_SREF) ? SREF_LD : PDOWN_LD;
          end else begin
            bad_d = 1'b1;
          end
        end
      end
      ST_WAKE: begin
        if (zero_i) state_d = ST_READY;
        else        dec_o   = 1'b1;
      end
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_q   <= bad_d;
    end
  end

  assign state_o   = state_q;
  assign illegal_o = bad_q;
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
  import cke_pwr_pkg::*;
#(
  parameter int INIT_CYCLES       = 200,
  parameter int SREF_EXIT_CYCLES  = 200,
  parameter int PDOWN_EXIT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_i,
  input  logic [2:0] cmd_i,
  input  logic       banks_idle_i,
  output logic [2:0] state_o,
  output logic       cmd_accept_o,
  output logic       illegal_o,
  output logic       output_hiz_o
);
  localparam int MAX_A = (INIT_CYCLES > SREF_EXIT_CYCLES) ? INIT_CYCLES : SREF_EXIT_CYCLES;
  localparam int MAX_C = (MAX_A > PDOWN_EXIT_CYCLES) ? MAX_A : PDOWN_EXIT_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             cke_q, fall;
  logic             ld, dec, zero;
  logic [CNT_W-1:0] ld_val;
  pwr_state_e       st;

  cke_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cke_q_o(cke_q), .fall_o(fall)
  );

  pwr_down_timer #(.CNT_W(CNT_W), .RST_VAL(INIT_CYCLES - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .load_val_i(ld_val),
    .dec_i(dec), .zero_o(zero)
  );

  pwr_state_fsm #(
    .CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES),
    .SREF_CYCLES(SREF_EXIT_CYCLES), .PDOWN_CYCLES(PDOWN_EXIT_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cmd_i(pwr_cmd_e'(cmd_i)),
    .banks_idle_i(banks_idle_i), .fall_i(fall), .zero_i(zero),
    .state_o(st), .load_o(ld), .load_val_o(ld_val), .dec_o(dec),
    .illegal_o(illegal_o)
  );

  assign state_o      = st;
  assign cmd_accept_o = (st == ST_READY);
  assign output_hiz_o = ~cke_q | (st != ST_READY);
endmodule

// File: rtl/cke_power_ctrl_chk.sv
module cke_power_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_i,
  input logic [2:0] cmd_i,
  input logic       banks_idle_i,
  input logic [2:0] state_o,
  input logic       cmd_accept_o,
  input logic       illegal_o,
  input logic       output_hiz_o,
  input logic       cke_q
);
  logic low_pwr;
  assign low_pwr = (state_o == 3'd2) || (state_o == 3'd3);

  p_pwrup_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !(cke_i && cmd_i == 3'd0)) |=> state_o == 3'd0);

  p_sref_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && cke_q && !cke_i && cmd_i == 3'd2 && banks_idle_i)
      |=> state_o == 3'd3);

  p_busy_sref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && cke_q && !cke_i && cmd_i == 3'd2 && !banks_idle_i)
      |=> (state_o == 3'd1 && illegal_o));

  p_no_accept_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> !cmd_accept_o);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && !cke_i) |=> ($stable(state_o) && !illegal_o));

  p_hiz_lowpwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_pwr |-> output_hiz_o);

  p_bad_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (low_pwr && cke_i && cmd_i > 3'd1) |=> (illegal_o && $stable(state_o)));
endmodule

bind cke_power_ctrl cke_power_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cmd_i(cmd_i),
  .banks_idle_i(banks_idle_i), .state_o(state_o), .cmd_accept_o(cmd_accept_o),
  .illegal_o(illegal_o), .output_hiz_o(output_hiz_o), .cke_q(cke_q)
);

// File: tb/sim_cke_power_ctrl.sv
`timescale 1ns/1ps
module sim_cke_power_ctrl;
  localparam int S_WAIT = 0, S_RDY = 1, S_PD = 2, S_SR = 3, S_WK = 4;
  localparam int C_DS = 0, C_NOP = 1, C_AREF = 2, C_ACT = 3, C_RD = 4, C_WR = 5;
  localparam int NV = 21;
  // {req[3:0], cke, cmd[2:0], idle, state[2:0], accept, illegal, hiz}
  localparam logic [14:0] VEC [NV] = '{
    {4'd7, 1'b1, 3'(C_NOP),  1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R7
    {4'd9, 1'b0, 3'(C_AREF), 1'b0, 3'(S_RDY), 1'b1, 1'b1, 1'b1}, // R9 busy banks
    {4'd7, 1'b1, 3'(C_NOP),  1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R7
    {4'd9, 1'b0, 3'(C_ACT),  1'b1, 3'(S_RDY), 1'b1, 1'b1, 1'b1}, // R9 bad command
    {4'd7, 1'b1, 3'(C_DS),   1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R7
    {4'd3, 1'b0, 3'(C_NOP),  1'b0, 3'(S_RDY), 1'b1, 1'b1, 1'b1}, // R3 busy
    {4'd7, 1'b1, 3'(C_NOP),  1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R7
    {4'd3, 1'b0, 3'(C_NOP),  1'b1, 3'(S_PD),  1'b0, 1'b0, 1'b1}, // R3 entry
    {4'd6, 1'b0, 3'(C_ACT),  1'b1, 3'(S_PD),  1'b0, 1'b0, 1'b1}, // R6
    {4'd6, 1'b0, 3'(C_AREF), 1'b0, 3'(S_PD),  1'b0, 1'b0, 1'b1}, // R6
    {4'd8, 1'b1, 3'(C_RD),   1'b1, 3'(S_PD),  1'b0, 1'b1, 1'b1}, // R8
    {4'd5, 1'b1, 3'(C_NOP),  1'b1, 3'(S_WK),  1'b0, 1'b0, 1'b1}, // R5
    {4'd5, 1'b1, 3'(C_NOP),  1'b1, 3'(S_WK),  1'b0, 1'b0, 1'b1}, // R5
    {4'd5, 1'b1, 3'(C_NOP),  1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R5
    {4'd3, 1'b0, 3'(C_DS),   1'b1, 3'(S_PD),  1'b0, 1'b0, 1'b1}, // R3
    {4'd5, 1'b1, 3'(C_DS),   1'b1, 3'(S_WK),  1'b0, 1'b0, 1'b1}, // R5
    {4'd10,1'b0, 3'(C_ACT),  1'b0, 3'(S_WK),  1'b0, 1'b0, 1'b1}, // R10
    {4'd5, 1'b1, 3'(C_NOP),  1'b1, 3'(S_RDY), 1'b1, 1'b0, 1'b0}, // R5
    {4'd2, 1'b0, 3'(C_AREF), 1'b1, 3'(S_SR),  1'b0, 1'b0, 1'b1}, // R2
    {4'd6, 1'b0, 3'(C_NOP),  1'b1, 3'(S_SR),  1'b0, 1'b0, 1'b1}, // R6
    {4'd8, 1'b1, 3'(C_WR),   1'b1, 3'(S_SR),  1'b0, 1'b1, 1'b1}  // R8
  };

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b0, idle = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [2:0] st;
  logic acc, ill, hiz;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cke_power_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cmd_i(cmd), .banks_idle_i(idle),
    .state_o(st), .cmd_accept_o(acc), .illegal_o(ill), .output_hiz_o(hiz)
  );

  task automatic step(input logic k, input int c, input logic bi);
    @(negedge clk);
    cke = k; cmd = 3'(c); idle = bi;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input int rq, input int es, input logic ea,
                       input logic ei, input logic eh);
    checks++;
    if (int'(st) != es || acc !== ea || ill !== ei || hiz !== eh) begin
      fails++;
      $display("FAIL R%0d: state/acc/ill/hiz actual %0d/%b/%b/%b expected %0d/%b/%b/%b",
               rq, st, acc, ill, hiz, es, ea, ei, eh);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #35;
    check(1, S_WAIT, 1'b0, 1'b0, 1'b1);               // R1 reset state
    rst_n = 1'b1;
    // R1: broken run restarts the lockout count
    for (int i = 0; i < 150; i++) step(1'b1, C_DS, 1'b1);
    check(1, S_WAIT, 1'b0, 1'b0, 1'b1);
    step(1'b1, C_NOP, 1'b1);
    check(1, S_WAIT, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 199; i++) step(1'b1, C_DS, 1'b1);
    check(1, S_WAIT, 1'b0, 1'b0, 1'b1);               // R1 one short
    step(1'b1, C_DS, 1'b1);
    check(1, S_RDY, 1'b1, 1'b0, 1'b0);                // R1 200th good cycle

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][10], int'(VEC[v][9:7]), VEC[v][6]);
      check(int'(VEC[v][14:11]), int'(VEC[v][5:3]), VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R4: self-refresh wake lasts 200 edges
    step(1'b1, C_NOP, 1'b1);
    check(4, S_WK, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 198; i++) step(1'b1, C_NOP, 1'b1);
    check(4, S_WK, 1'b0, 1'b0, 1'b1);
    step(1'b1, C_DS, 1'b1);
    check(4, S_WK, 1'b0, 1'b0, 1'b1);                 // 199th edge
    step(1'b1, C_NOP, 1'b1);
    check(4, S_RDY, 1'b1, 1'b0, 1'b0);                // 200th edge

    // R7: low clock-enable in ready still requests high impedance
    step(1'b0, C_ACT, 1'b1);
    check(7, S_RDY, 1'b1, 1'b1, 1'b1);

    // R1: reset mid-run returns to the wait state
    @(negedge clk); rst_n = 1'b0;
    #2;
    check(1, S_WAIT, 1'b0, 1'b0, 1'b1);
    finish_run();
  end
endmodule